// File: doc/BRIEF.md
# Selectable-Polynomial PRBS Generator

This block produces a pseudo-random bit stream from one shared 31-bit Fibonacci shift register. A 3-bit code picks one of eight feedback polynomials, and the top bit of that code also fixes how many sequence bits are emitted per clock: 8 when it is 0, 10 when it is 1. Each clock in which the engine runs, the register advances by that many steps. The bits produced in that clock are presented as one parallel word together with a valid strobe.

Generation needs both a generator enable and an engine start. A local clear returns the register to its all-ones seed. A load port writes any seed, so a checker can synchronise to the stream by loading the bits it has received. The polynomial code is captured on the first running clock and held until the engine stops. A change to the code during a run therefore has no effect.

Top module: `prbs_gen`

## Requirements
- R1: After `rst_ni` is low, `valid_o` is 0, `word_o` is 0 and the shift register holds all ones.
- R2: Each sequence bit b(k) is the XOR of b(k-e) over the non-constant exponents e of the selected polynomial. Code 0: x^16+x^5+x^4+x^3+1. Code 1: x^16+x^15+x^13+x^4+1. Codes 2 and 6: x^31+x^28+1. Codes 3 and 7: x^7+x^6+1. Code 4: x^15+x^14+1. Code 5: x^23+x^18+1. The 31 register bits hold the last 31 sequence bits.
- R3: When select bit 2 is 0, each word carries 8 new bits in `word_o[7:0]` and `word_o[9:8]` is 0. When it is 1, each word carries 10 new bits.
- R4: `word_o[0]` is the earliest bit generated in its clock, and higher indices are later bits. Consecutive words continue the sequence with no bit skipped or repeated.
- R5: `valid_o` is 1 in the cycle after a clock edge at which `en_i` and `start_i` were both 1 and neither `lclr_i` nor `load_i` was 1. Otherwise `valid_o` is 0.
- R6: `lclr_i` sets the register to all ones, clears `word_o` and drops `valid_o`. It takes priority over load and run.
- R7: `load_i` writes `seed_i` into the register and drops `valid_o`. It takes priority over run. A zero seed is replaced by all ones.
- R8: The polynomial code is taken from `sel_i` at the first running edge and held while the engine keeps running. Changes to `sel_i` during a run are ignored. A new code takes effect on the next run.
- R9: While not running, the register and `word_o` hold their values. Resuming continues the sequence where it paused.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Generator enable |
| start_i | input | 1 | Engine start |
| lclr_i | input | 1 | Local clear to the all-ones seed |
| load_i | input | 1 | Seed load strobe |
| seed_i | input | 31 | Seed value for load |
| sel_i | input | 3 | Polynomial and word-width code |
| word_o | output | 10 | Generated word, earliest bit at index 0 |
| valid_o | output | 1 | Word is new this cycle |

## Verification
The bench compares every word for all eight codes against a model built from the polynomial recurrences. A wrong tap, a reversed bit order or a dropped step shows up as a word mismatch within the first few words. It changes `sel_i` in the middle of a run; a design that follows the live code would switch polynomial or width at once instead of after the stop. Pausing with one control low and then resuming exposes a design that keeps stepping, or that loses its place, while stalled. Loads of a nonzero seed and of a zero seed, a load at the same time as running, and a clear in mid-run check the priorities. A design that lets run win over load would emit a valid word and skip the seed. A design that accepts a zero seed would lock up and emit only zeros.

// File: rtl/prbs_pkg.sv
package prbs_pkg;

    localparam int unsigned LFSR_W   = 31;
    localparam int unsigned WIDE_W   = 10;
    localparam int unsigned NARROW_W = 8;
    localparam int unsigned SEL_W    = 3;

    typedef logic [LFSR_W-1:0] lfsr_t;
    typedef logic [SEL_W-1:0]  code_t;

    localparam lfsr_t SEED_ONES = '1;

    typedef struct packed {
        lfsr_t             state;
        logic [WIDE_W-1:0] word;
        logic              valid;
        logic              running;
        code_t             code;
    } gen_regs_t;

endpackage

// File: rtl/prbs_tap_sel.sv
module prbs_tap_sel
    import prbs_pkg::*;
(
    input  code_t code_i,
    output lfsr_t mask_o,
    output logic  wide_o
);
    // Bit (e-1) of the mask is set for each non-constant exponent e.
    always_comb begin
        unique case (code_i)
            3'd0:    mask_o = lfsr_t'(32'h0000_801C);
            3'd1:    mask_o = lfsr_t'(32'h0000_D008);
            3'd2:    mask_o = lfsr_t'(32'h4800_0000);
            3'd3:    mask_o = lfsr_t'(32'h0000_0060);
            3'd4:    mask_o = lfsr_t'(32'h0000_6000);
            3'd5:    mask_o = lfsr_t'(32'h0042_0000);
            3'd6:    mask_o = lfsr_t'(32'h4800_0000);
            default: mask_o = lfsr_t'(32'h0000_0060);
        endcase
    end

    assign wide_o = code_i[SEL_W-1];

endmodule

// File: rtl/prbs_stepper.sv
module prbs_stepper #(
    parameter int unsigned W     = 31,
    parameter int unsigned STEPS = 10,
    parameter int unsigned SHORT = 8
) (
    input  logic [W-1:0]     state_i,
    input  logic [W-1:0]     mask_i,
    input  logic             wide_i,
    output logic [W-1:0]     state_o,
    output logic [STEPS-1:0] bits_o
);
    localparam int unsigned PAD = STEPS - SHORT;

    logic [W-1:0]     chain [0:STEPS];
    logic [STEPS-1:0] fb;

    assign chain[0] = state_i;

    for (genvar g = 0; g < STEPS; g++) begin : g_step
        assign fb[g]         = ^(chain[g] & mask_i);
        assign chain[g+1]    = {chain[g][W-2:0], fb[g]};
    end

    assign state_o = wide_i ? chain[STEPS] : chain[SHORT];
    assign bits_o  = wide_i ? fb : {{PAD{1'b0}}, fb[SHORT-1:0]};

endmodule

// File: rtl/prbs_gen.sv
module prbs_gen
    import prbs_pkg::*;
(
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              en_i,
    input  logic              start_i,
    input  logic              lclr_i,
    input  logic              load_i,
    input  logic [LFSR_W-1:0] seed_i,
    input  logic [SEL_W-1:0]  sel_i,
    output logic [WIDE_W-1:0] word_o,
    output logic              valid_o
);
    gen_regs_t         r_d, r_q;
    logic              run;
    code_t             code_eff;
    lfsr_t             mask;
    logic              wide;
    lfsr_t             step_state;
    logic [WIDE_W-1:0] step_bits;

    assign run      = en_i & start_i;
    assign code_eff = r_q.running ? r_q.code : sel_i;

    prbs_tap_sel i_taps (
        .code_i (code_eff),
        .mask_o (mask),
        .wide_o (wide)
    );

    prbs_stepper #(
        .W     (LFSR_W),
        .STEPS (WIDE_W),
        .SHORT (NARROW_W)
    ) i_step (
        .state_i (r_q.state),
        .mask_i  (mask),
        .wide_i  (wide),
        .state_o (step_state),
        .bits_o  (step_bits)
    );

    always_comb begin
        r_d         = r_q;
        r_d.code    = code_eff;
        r_d.running = run & ~lclr_i;
        r_d.valid   = 1'b0;
        if (lclr_i) begin
            r_d.state = SEED_ONES;
            r_d.word  = '0;
        end else if (load_i) begin
            r_d.state = (seed_i == '0) ? SEED_ONES : seed_i;
        end else if (run) begin
            r_d.state = step_state;
            r_d.word  = step_bits;
            r_d.valid = 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            r_q.state   <= SEED_ONES;
            r_q.word    <= '0;
            r_q.valid   <= 1'b0;
            r_q.running <= 1'b0;
            r_q.code    <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign word_o  = r_q.word;
    assign valid_o = r_q.valid;

    a_r3_narrow_top_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (valid_o && !r_q.code[SEL_W-1]) |-> (word_o[WIDE_W-1:NARROW_W] == '0));

    a_r5_valid_needs_run: assert property (@(posedge clk_i) disable iff (!rst_ni)
        valid_o |-> $past(en_i && start_i && !lclr_i && !load_i));

    a_r6_clear_to_seed: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $past(lclr_i) |-> (r_q.state == SEED_ONES && !valid_o && word_o == '0));

    a_r7_never_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
        r_q.state != '0);

    a_r8_code_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (r_q.running && $past(r_q.running)) |-> $stable(r_q.code));

    a_r9_idle_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ($past(!(en_i && start_i)) && $past(!lclr_i) && $past(!load_i))
        |-> ($stable(r_q.state) && $stable(word_o)));

endmodule

// File: tb/test_prbs_gen.sv
module test_prbs_gen;

    logic        clk_i = 1'b0;
    logic        rst_ni = 1'b0;
    logic        en_i = 1'b0, start_i = 1'b0, lclr_i = 1'b0, load_i = 1'b0;
    logic [30:0] seed_i = '0;
    logic [2:0]  sel_i = '0;
    logic [9:0]  word_o;
    logic        valid_o;

    int errors = 0;
    int checks = 0;

    logic [30:0] m_st;
    logic [2:0]  m_code;

    always #5 clk_i = ~clk_i;

    prbs_gen i_prbs_gen (
        .clk_i, .rst_ni, .en_i, .start_i, .lclr_i, .load_i,
        .seed_i, .sel_i, .word_o, .valid_o
    );

    typedef struct packed { logic [2:0] code; logic [7:0] ncyc; } vec_t;
    localparam vec_t VECS [8] = '{
        '{3'd0, 8'd6}, '{3'd1, 8'd6}, '{3'd2, 8'd7}, '{3'd3, 8'd5},
        '{3'd4, 8'd6}, '{3'd5, 8'd6}, '{3'd6, 8'd7}, '{3'd7, 8'd5}
    };

    // Recurrence b(k) = XOR of b(k-e); st[e-1] holds b(k-e).
    function automatic logic fbk(input logic [2:0] c, input logic [30:0] st);
        case (c)
            3'd0:         return st[16-1] ^ st[5-1] ^ st[4-1] ^ st[3-1];
            3'd1:         return st[16-1] ^ st[15-1] ^ st[13-1] ^ st[4-1];
            3'd2, 3'd6:   return st[31-1] ^ st[28-1];
            3'd4:         return st[15-1] ^ st[14-1];
            3'd5:         return st[23-1] ^ st[18-1];
            default:      return st[7-1] ^ st[6-1];
        endcase
    endfunction

    function automatic logic [9:0] model_word();
        logic [9:0] w = '0;
        int n = m_code[2] ? 10 : 8;
        for (int i = 0; i < n; i++) begin
            logic b = fbk(m_code, m_st);
            w[i] = b;
            m_st = {m_st[29:0], b};
        end
        return w;
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk_i);
        #1;
    endtask

    task automatic setin(input logic e, input logic s, input logic c, input logic l);
        @(negedge clk_i);
        en_i = e; start_i = s; lclr_i = c; load_i = l;
    endtask

    task automatic run_cmp(input int n, input string req);
        for (int k = 0; k < n; k++) begin
            logic [9:0] exp_w;
            setin(1, 1, 0, 0);
            tick();
            exp_w = model_word();
            chk(valid_o === 1'b1, req, valid_o, 1);
            chk(word_o === exp_w, req, word_o, exp_w);
        end
    endtask

    initial begin
        #2_000_000;
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        // R1 reset state
        repeat (3) @(posedge clk_i);
        #1;
        chk(valid_o === 1'b0, "R1 valid", valid_o, 0);
        chk(word_o === 10'd0, "R1 word", word_o, 0);
        @(negedge clk_i);
        rst_ni = 1'b1;
        m_st = '1; m_code = 3'd0; sel_i = 3'd0;
        run_cmp(3, "R1 R2 R4 seed all ones");

        // Table walk: every code from a cleared register
        foreach (VECS[v]) begin
            setin(0, 0, 1, 0);
            tick();
            chk(valid_o === 1'b0 && word_o === 10'd0, "R6 clear", {valid_o, word_o}, 0);
            m_st = '1;
            sel_i = VECS[v].code;
            m_code = VECS[v].code;
            run_cmp(int'(VECS[v].ncyc), "R2 R3 R4");
            if (!VECS[v].code[2])
                chk(word_o[9:8] === 2'b00, "R3 narrow top bits", word_o[9:8], 0);
        end
        setin(0, 0, 0, 0);
        tick();
        chk(valid_o === 1'b0, "R5 stop", valid_o, 0);

        // R9 pause with enable low, then with start low
        begin
            logic [9:0] held;
            setin(0, 0, 1, 0); tick();
            m_st = '1; sel_i = 3'd3; m_code = 3'd3;
            run_cmp(3, "R9 pre");
            held = word_o;
            setin(0, 1, 0, 0); tick();
            chk(valid_o === 1'b0 && word_o === held, "R5 R9 enable low", {valid_o, word_o}, {1'b0, held});
            setin(1, 0, 0, 0); tick();
            chk(valid_o === 1'b0 && word_o === held, "R5 R9 start low", {valid_o, word_o}, {1'b0, held});
            run_cmp(3, "R9 resume");
        end

        // R8 mid-run code change ignored, applied on next run
        setin(0, 0, 1, 0); tick();
        m_st = '1; sel_i = 3'd0; m_code = 3'd0;
        run_cmp(2, "R8 before change");
        sel_i = 3'd5;
        run_cmp(3, "R8 change ignored");
        setin(0, 0, 0, 0); tick();
        m_code = 3'd5;
        run_cmp(3, "R8 new code after stop");

        // R7 load nonzero seed while idle
        setin(0, 0, 0, 0);
        seed_i = 31'h1234_5678; load_i = 1'b1;
        tick();
        chk(valid_o === 1'b0, "R7 load valid", valid_o, 0);
        m_st = 31'h1234_5678; sel_i = 3'd2; m_code = 3'd2;
        run_cmp(4, "R7 seeded stream");

        // R7 load beats run
        setin(1, 1, 0, 1);
        seed_i = 31'h0ABC_DEF1;
        tick();
        chk(valid_o === 1'b0, "R7 load over run", valid_o, 0);
        m_st = 31'h0ABC_DEF1;
        run_cmp(2, "R7 after load over run");

        // R7 zero seed replaced by all ones
        setin(0, 0, 0, 1);
        seed_i = '0;
        tick();
        setin(0, 0, 0, 0); tick();
        m_st = '1; sel_i = 3'd4; m_code = 3'd4;
        run_cmp(3, "R7 zero seed");

        // R6 clear mid-run beats load and run
        setin(1, 1, 1, 1);
        seed_i = 31'h5555_5555;
        tick();
        chk(valid_o === 1'b0 && word_o === 10'd0, "R6 clear priority", {valid_o, word_o}, 0);
        m_st = '1; sel_i = 3'd1; m_code = 3'd1;
        run_cmp(3, "R6 restart after clear");

        setin(0, 0, 0, 0);
        tick();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule